// File: doc/BRIEF.md
# Synchronous Burst SRAM with Interleaved Burst Counter

This block is a synthesizable single-port static RAM. It takes its clocked inputs through registers at the rising clock edge. An internal two-bit beat counter produces the later addresses of a four-beat cache-line burst. A new burst starts when either of two address-strobe inputs is asserted. One strobe belongs to the processor side and is honoured only while chip enable is high, so the address bus can carry an access for another device. The other strobe belongs to the controller side. An advance input steps through the beats in interleaved order. The low two address bits of each beat are the loaded low bits XOR the beat count.

The word is split into two 9-bit lanes, and each lane has its own write enable. The write is self-timed. It commits at the clock edge that follows the capture of its inputs, and it needs no pulse shaping from outside. The same edge registers read data for the captured address, in read-first fashion. An output-enable input gates that registered read data combinationally. The full device size is reached with `ADDR_W = 16`. The default is kept smaller so that the elaborated array stays small.

Top module: `burst_sram`

## Requirements
- R1: While reset is high, the read-data register is held at zero, so with output enable high the data output reads all zeros.
- R2: A word whose address is captured at clock edge N shows on the data output after edge N+1, which is one cycle after capture.
- R3: A burst started by the controller strobe loads the external address and clears the beat count. The lane write enables captured with it are honoured, and the write commits at the next edge.
- R4: When the processor strobe is asserted with chip enable high, it loads the external address and clears the beat count. The write enables of that access are ignored, even when the controller strobe is also asserted, so the stored word is left unchanged.
- R5: When chip enable is low, the processor strobe has no effect, and the address and beat count keep their values.
- R6: Each edge with advance high and no start steps the beat count by one, modulo 4. The accessed low two address bits equal the loaded low bits XOR the count, and the upper bits do not change. From a start at low bits 2 the order is 2,3,0,1,2.
- R7: With no start and advance low, the accessed address is held, so the same word is read again.
- R8: Write-enable bit 0 writes data bits 8:0 and bit 1 writes bits 17:9. Each lane works independently, and a lane left disabled keeps its stored value.
- R9: Output enable is not registered. When it is low, the data output is zero in the same cycle. When it goes high again, the registered read data returns at once.
- R10: A start takes priority over advance. A start with advance high still loads the new address with a beat count of zero.
- R11: When a read and a write hit the same word at the same edge, the read returns the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | DATA_W | Write data |
| lane_we_i | input | LANES | Per-lane write enables (bit 0 is the low lane) |
| proc_start_i | input | 1 | Processor-side start strobe, gated by chip enable |
| ctrl_start_i | input | 1 | Controller-side start strobe |
| chip_en_i | input | 1 | Chip enable |
| adv_i | input | 1 | Burst advance |
| out_en_i | input | 1 | Combinational output enable |
| rdata_o | output | DATA_W | Read data, zero while output enable is low |

## Verification
The bench builds the block with an 8-bit address, 18-bit data and 9-bit lanes. This keeps the bench's reference memory small, while the upper address bits still take part and can be checked for staying unchanged through a burst. With two lanes, every write-enable combination can be used, including partial writes over a full word. With a two-bit beat counter, a burst that wraps past its fourth beat takes only a few cycles, and so do interleaved orders from two different starting low bits.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Width of the beat counter; a burst spans 2**BEAT_W words.
  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  // Which strobe (if any) opened an access at this edge.
  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_PROC = 2'd1,
    START_CTRL = 2'd2
  } start_e;

  // Interleaved beat order: loaded low bits XOR beat count.
  function automatic beat_t beat_offset(input beat_t base_lo, input beat_t count);
    return base_lo ^ count;
  endfunction

endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_start_i,
  input  logic              ctrl_start_i,
  input  logic              chip_en_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output start_e            start_o,
  output logic [ADDR_W-1:0] acc_addr_o
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  beat_t             cnt_q;
  logic              load;

  // The processor strobe counts only with chip enable; it wins over the
  // controller strobe, so a joint start is treated as a read.
  always_comb begin
    if (proc_start_i && chip_en_i) start_o = START_PROC;
    else if (ctrl_start_i)         start_o = START_CTRL;
    else                           start_o = START_NONE;
  end

  assign load = (start_o != START_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (adv_i) begin
      cnt_q  <= cnt_q + beat_t'(1);
    end
  end

  assign acc_addr_o = {base_q[ADDR_W-1 -: HI_W], beat_offset(base_q[BEAT_W-1:0], cnt_q)};

  // R10: any start loads the address and clears the count, even with advance high
  a_r10_load_clears: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0) && (base_q == $past(addr_i)));

  // R6: advance without start steps the count by one, modulo the burst length
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_i) |=> cnt_q == beat_t'($past(cnt_q) + beat_t'(1)));

  // R6: upper address bits never move during a burst
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_i) |=> $stable(base_q));

  // R7: no start and no advance keeps the accessed address
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_i) |=> $stable(acc_addr_o));

  // R5: processor strobe with chip enable low alone changes nothing
  a_r5_ce_gate: assert property (@(posedge clk) disable iff (rst)
    (proc_start_i && !chip_en_i && !ctrl_start_i && !adv_i) |=> $stable(base_q) && $stable(cnt_q));

endmodule

// File: rtl/sbsram_wcap.sv
module sbsram_wcap
  import sbsram_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  start_e            start_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  lane_we_o,
  output logic [DATA_W-1:0] wdata_o
);

  logic [LANES-1:0] we_masked;

  // A processor-opened access is a read: its write enables are dropped.
  assign we_masked = (start_i == START_PROC) ? '0 : lane_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_we_o <= '0;
      wdata_o   <= '0;
    end else begin
      lane_we_o <= we_masked;
      wdata_o   <= wdata_i;
    end
  end

  // R4: the access after a processor start writes nothing
  a_r4_no_write: assert property (@(posedge clk) disable iff (rst)
    (start_i == START_PROC) |=> lane_we_o == '0);

  // R3: otherwise the captured enables are exactly the presented ones
  a_r3_we_follow: assert property (@(posedge clk) disable iff (rst)
    (start_i != START_PROC) |=> lane_we_o == $past(lane_we_i));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  localparam int LANES = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  // One narrow memory per lane, each a plain read-first block RAM.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else     rd_q <= mem[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int LANE_W = 9,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic              proc_start_i,
  input  logic              ctrl_start_i,
  input  logic              chip_en_i,
  input  logic              adv_i,
  input  logic              out_en_i,
  output logic [DATA_W-1:0] rdata_o
);

  start_e            start;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  we_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk          (clk),
    .rst          (rst),
    .proc_start_i (proc_start_i),
    .ctrl_start_i (ctrl_start_i),
    .chip_en_i    (chip_en_i),
    .adv_i        (adv_i),
    .addr_i       (addr_i),
    .start_o      (start),
    .acc_addr_o   (acc_addr)
  );

  sbsram_wcap #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_wcap (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .lane_we_i (lane_we_i),
    .wdata_i   (wdata_i),
    .lane_we_o (we_q),
    .wdata_o   (wd_q)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (acc_addr),
    .lane_we_i (we_q),
    .wdata_i   (wd_q),
    .rdata_o   (rd_q)
  );

  // Unregistered output gate.
  assign rdata_o = out_en_i ? rd_q : '0;

  // R1: the first cycle after reset still shows the cleared read register
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && out_en_i) |-> rdata_o == '0);

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 18;
  localparam int LANE_W = 9;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [LANES-1:0]  we = '0;
  logic p_st = 1'b0, c_st = 1'b0, ce = 1'b1, adv = 1'b0, oe = 1'b1;
  logic [DATA_W-1:0] dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .lane_we_i    (we),
    .proc_start_i (p_st),
    .ctrl_start_i (c_st),
    .chip_en_i    (ce),
    .adv_i        (adv),
    .out_en_i     (oe),
    .rdata_o      (dout)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int                due;
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;
  item_t q[$];
  item_t it;

  // Reference model state
  logic [DATA_W-1:0] mm [DEPTH];
  logic [LANES-1:0]  mv [DEPTH];
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_cnt = '0;

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: drives one cycle of inputs and pushes the expected read result.
  task automatic drive(input bit p, input bit c, input bit e, input bit a,
                       input logic [LANES-1:0] w, input logic [ADDR_W-1:0] ad,
                       input logic [DATA_W-1:0] wd, input string tag, input bit chk);
    logic [ADDR_W-1:0] eff;
    logic [LANES-1:0]  lanes;
    bit                proc;
    @(negedge clk); #1;
    p_st = p; c_st = c; ce = e; adv = a; we = w; addr = ad; wdata = wd;
    proc = p && e;
    if (proc || c) begin
      m_base = ad;
      m_cnt  = 2'd0;
    end else if (a) begin
      m_cnt = m_cnt + 2'd1;
    end
    lanes = proc ? '0 : w;
    eff = {m_base[ADDR_W-1:2], m_base[1:0] ^ m_cnt};
    if (chk && (mv[eff] == '1)) q.push_back('{cyc + 2, mm[eff], tag});
    for (int l = 0; l < LANES; l++) begin
      if (lanes[l]) begin
        mm[eff][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
        mv[eff][l] = 1'b1;
      end
    end
  endtask

  task automatic idle(input string tag, input bit chk);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, tag, chk);
  endtask

  // Monitor: compares every due item at the negedge of its cycle.
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].due == cyc) begin
      it = q.pop_front();
      check(it.tag, dout, oe ? it.exp : '0);
    end
  end

  function automatic logic [DATA_W-1:0] wpat(input int k);
    return DATA_W'(18'h0A000 + k * 18'h01111);
  endfunction

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mm[i] = '0;
      mv[i] = '0;
    end
    // R1: read register cleared during reset
    repeat (2) @(posedge clk);
    @(negedge clk); check("R1", dout, '0);
    @(negedge clk); check("R1", dout, '0);
    #1 rst = 1'b0;

    // R3: controller burst writes at 0x10..0x13 in interleaved order
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h10, wpat(0), "R3", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 8'h55, wpat(1), "R6", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 8'h55, wpat(2), "R6", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 8'h55, wpat(3), "R6", 1'b1);

    // R4: processor start reads 0x12; its write enables are ignored
    drive(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 8'h12, 18'h3FFFF, "R4", 1'b1);
    // R6: order 3,0,1 then wrap to 2
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, "R6", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, "R6", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, "R6", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, "R6", 1'b1);
    // R7: hold
    idle("R7", 1'b1);
    idle("R7", 1'b1);
    // R5: processor strobe with chip enable low is ignored
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 8'h10, 18'h12345, "R5", 1'b1);
    idle("R5", 1'b1);

    // R10: controller start with advance high, low bits 01 -> order 1,0,3,2
    drive(1'b0, 1'b1, 1'b1, 1'b1, '0, 8'h11, '0, "R10", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, "R6", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, "R6", 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, '0, "R6", 1'b1);

    // R8 / R11: lane writes at 0x20 with read-first results
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h20, 18'h1A5A5, "R8", 1'b1);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 8'h20, 18'h2C3C3, "R11", 1'b1);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 8'h20, 18'h3F0F0, "R11", 1'b1);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h20, 18'h00000, "R8", 1'b1);

    // R2: fresh load read one cycle after capture
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h13, '0, "R2", 1'b1);
    idle("R2", 1'b1);
    idle("R7", 1'b0);

    // R9: output enable acts within the cycle (0x13 holds wpat(3))
    @(negedge clk); #2;
    oe = 1'b0; #1 check("R9", dout, '0);
    oe = 1'b1; #1 check("R9", dout, wpat(3));
    oe = 1'b0;
    idle("R9", 1'b1);
    idle("R9", 1'b1);
    @(negedge clk); #2 oe = 1'b1;

    repeat (4) idle("R7", 1'b0);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: actual %0d pending results expected 0", q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule